// File: doc/BRIEF.md
# PWM Fault Input Acceptance Logic

This block takes one already-synchronised control input for a PWM generator, such as a fault or current-limit line, and decides when that input counts as an active condition for the PWM core. The acceptance rule is chosen at run time. It can follow the input level, react to a rising edge or to any edge, or use a latched variant of each of these. In the latched variants, an accepted event sets a set/reset latch. The latch clears only when a termination event arrives while the selected termination qualifier is true.

The termination qualifier comes from one of eight choices: a constant one, duty-cycle-active, blanking-active, generator-triggered, three external lines, or a constant zero. An optional inversion follows the selection. A software level can be ORed into one of three points: the conditioned input, the acceptance qualifier, or the termination qualifier.

The whole configuration arrives as a 16-bit control word, which is captured every clock. Any reserved code in that word parks the block with its output inactive.

Top module: `fai_top`

## Requirements
- R1: `ctrl_i` is captured into the configuration register on every rising clock edge and takes effect from the following cycle. Reset clears it to zero, which selects level acceptance, a set-dominant latch, no termination qualifier, no inversion and software routing to the input. Field positions: [2:0] acceptance mode, [3] reset-dominant latch, [6:4] termination qualifier select, [7] qualifier inversion, [9:8] software route, [10] software level.
- R2: Mode 000 (level): `active_o` equals `fault_i & acc_qual_i` in the same cycle. Both terms include any software contribution.
- R3: Mode 001 (rising edge): `active_o` is high for one cycle when the conditioned input is high, its value in the previous cycle was low, and the acceptance qualifier is high.
- R4: Mode 010 (any edge): `active_o` is high for one cycle when the conditioned input differs from its previous-cycle value and the acceptance qualifier is high.
- R5: Mode 011 (latched): a cycle with the input high and the acceptance qualifier high sets the latch. `active_o` shows the latch state from the next cycle on.
- R6: Modes 100 (latched rising) and 101 (latched any edge) set the latch with the R3 and R4 events respectively. `active_o` shows the latch state.
- R7: In the latched modes, the latch clears only in a cycle where `term_evt_i` and the termination qualifier are both high.
- R8: When a set and a clear fall in the same cycle, the latch ends clear if bit 3 is 1 and ends set if bit 3 is 0.
- R9: Termination qualifier select: 000 gives constant 1, 001 `duty_act_i`, 010 `blank_act_i`, 011 `gen_trig_i`, 100 to 110 `ext_src_i[0]` to `ext_src_i[2]`, and 111 gives constant 0.
- R10: Bit 7 set inverts the selected termination qualifier before any software contribution is added.
- R11: The software level (bit 10) is ORed into one point chosen by route code: 00 the conditioned input, 01 the acceptance qualifier, 10 the termination qualifier.
- R12: Acceptance codes 110 and 111, and route code 11, force `active_o` low and hold the latch clear.
- R13: In the non-latched modes the latch is held clear, so switching into a latched mode starts with `active_o` low until a new set event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | 16 | Control word |
| fault_i | input | 1 | Synchronised control input to be accepted |
| acc_qual_i | input | 1 | Acceptance qualifier |
| term_evt_i | input | 1 | Termination event |
| duty_act_i | input | 1 | Duty-cycle-active qualifier source |
| blank_act_i | input | 1 | Blanking-active qualifier source |
| gen_trig_i | input | 1 | Generator-triggered qualifier source |
| ext_src_i | input | 3 | External qualifier sources |
| active_o | output | 1 | Accepted condition to the PWM core |

## Verification
A wrong configuration capture shows on `active_o` in the first cycle after the control word changes, because every mode decision feeds the output combinationally. A corrupted input-history bit causes a missed or spurious edge pulse in the same cycle in the edge modes. A wrong latch state appears on `active_o` immediately in the latched modes. In the non-latched modes the same fault stays hidden until a switch into a latched mode exposes it. For this reason the bench compares against its model on every clock and sweeps mode changes in both directions.

// File: rtl/fai_pkg.sv
`timescale 1ns/1ps
package fai_pkg;
  localparam int CFG_W   = 16;
  localparam int N_EXT   = 3;
  localparam int TQ_SEL_W = 3;
  localparam int N_TQ    = 1 << TQ_SEL_W;
  localparam int USED_W  = 11;

  typedef enum logic [2:0] {
    ACC_LEVEL    = 3'd0,
    ACC_RISE     = 3'd1,
    ACC_ANY      = 3'd2,
    ACC_LAT      = 3'd3,
    ACC_LAT_RISE = 3'd4,
    ACC_LAT_ANY  = 3'd5,
    ACC_RSV6     = 3'd6,
    ACC_RSV7     = 3'd7
  } acc_mode_e;

  typedef enum logic [1:0] {
    SW_TO_INPUT = 2'd0,
    SW_TO_AQUAL = 2'd1,
    SW_TO_TQUAL = 2'd2,
    SW_RSV      = 2'd3
  } sw_route_e;

  typedef enum logic [TQ_SEL_W-1:0] {
    TQ_NONE  = 3'd0,
    TQ_DUTY  = 3'd1,
    TQ_BLANK = 3'd2,
    TQ_TRIG  = 3'd3,
    TQ_EXT0  = 3'd4,
    TQ_EXT1  = 3'd5,
    TQ_EXT2  = 3'd6,
    TQ_ZERO  = 3'd7
  } tq_sel_e;

  // packed msb-first so the struct maps directly onto ctrl bits [10:0]
  typedef struct packed {
    logic      sw_lvl;
    sw_route_e sw_route;
    logic      tq_inv;
    tq_sel_e   tq_sel;
    logic      rst_dom;
    acc_mode_e mode;
  } cfg_t;
endpackage

// File: rtl/fai_cfg.sv
`timescale 1ns/1ps
module fai_cfg
  import fai_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] ctrl_i,
  output cfg_t             cfg_o,
  output logic             rsvd_o,
  output logic             latched_o
);
  cfg_t cfg_q;
  logic unused_hi;

  assign unused_hi = ^ctrl_i[CFG_W-1:USED_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_t'(ctrl_i[USED_W-1:0]);
  end

  always_comb begin
    rsvd_o = 1'b0;
    if (cfg_q.mode == ACC_RSV6 || cfg_q.mode == ACC_RSV7) rsvd_o = 1'b1;
    if (cfg_q.sw_route == SW_RSV) rsvd_o = 1'b1;
  end

  always_comb begin
    unique case (cfg_q.mode)
      ACC_LAT, ACC_LAT_RISE, ACC_LAT_ANY: latched_o = 1'b1;
      default:                            latched_o = 1'b0;
    endcase
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/fai_qual.sv
`timescale 1ns/1ps
module fai_qual
  import fai_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cfg_t             cfg_i,
  input  logic             duty_act_i,
  input  logic             blank_act_i,
  input  logic             gen_trig_i,
  input  logic [N_EXT-1:0] ext_src_i,
  output logic             tq_o
);
  logic [N_TQ-1:0] src;
  logic            sel;
  logic            sw_inj;

  assign src[TQ_NONE]  = 1'b1;
  assign src[TQ_DUTY]  = duty_act_i;
  assign src[TQ_BLANK] = blank_act_i;
  assign src[TQ_TRIG]  = gen_trig_i;
  assign src[TQ_ZERO]  = 1'b0;

  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    assign src[int'(TQ_EXT0) + g] = ext_src_i[g];
  end

  assign sel    = src[cfg_i.tq_sel];
  assign sw_inj = (cfg_i.sw_route == SW_TO_TQUAL) & cfg_i.sw_lvl;
  assign tq_o   = (sel ^ cfg_i.tq_inv) | sw_inj;

  p_tq_none_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.tq_sel == TQ_NONE && !cfg_i.tq_inv) |-> tq_o);
  p_tq_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.tq_sel == TQ_ZERO && !cfg_i.tq_inv && cfg_i.sw_route != SW_TO_TQUAL) |-> !tq_o);
  p_tq_sw_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.sw_route == SW_TO_TQUAL && cfg_i.sw_lvl) |-> tq_o);
endmodule

// File: rtl/fai_accept.sv
`timescale 1ns/1ps
module fai_accept
  import fai_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cfg_t cfg_i,
  input  logic rsvd_i,
  input  logic latched_i,
  input  logic fault_i,
  input  logic acc_qual_i,
  input  logic term_evt_i,
  input  logic tq_i,
  output logic active_o
);
  logic in_c, aq_c, prev_q, latch_q, latch_d;
  logic rise, any_e, det, set_evt, clr_evt;

  assign in_c = fault_i    | ((cfg_i.sw_route == SW_TO_INPUT) & cfg_i.sw_lvl);
  assign aq_c = acc_qual_i | ((cfg_i.sw_route == SW_TO_AQUAL) & cfg_i.sw_lvl);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= in_c;
  end

  assign rise  = in_c & ~prev_q;
  assign any_e = in_c ^ prev_q;

  always_comb begin
    unique case (cfg_i.mode)
      ACC_RISE, ACC_LAT_RISE: det = rise;
      ACC_ANY,  ACC_LAT_ANY:  det = any_e;
      default:                det = in_c;
    endcase
  end

  assign set_evt = det & aq_c;
  assign clr_evt = term_evt_i & tq_i;

  always_comb begin
    latch_d = latch_q;
    if (rsvd_i || !latched_i)      latch_d = 1'b0;
    else if (set_evt && clr_evt)   latch_d = ~cfg_i.rst_dom;
    else if (set_evt)              latch_d = 1'b1;
    else if (clr_evt)              latch_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) latch_q <= 1'b0;
    else         latch_q <= latch_d;
  end

  always_comb begin
    if (rsvd_i)         active_o = 1'b0;
    else if (latched_i) active_o = latch_q;
    else                active_o = set_evt;
  end

  p_rsvd_off_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd_i |-> !active_o);
  p_rdom_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latched_i && !rsvd_i && set_evt && clr_evt && cfg_i.rst_dom) |=> !latch_q);
  p_sdom_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latched_i && !rsvd_i && set_evt && clr_evt && !cfg_i.rst_dom) |=> latch_q);
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latched_i && !rsvd_i && latch_q && !clr_evt) |=> latch_q);
  p_nonlat_clr_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latched_i |=> !latch_q);
endmodule

// File: rtl/fai_top.sv
`timescale 1ns/1ps
module fai_top
  import fai_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] ctrl_i,
  input  logic             fault_i,
  input  logic             acc_qual_i,
  input  logic             term_evt_i,
  input  logic             duty_act_i,
  input  logic             blank_act_i,
  input  logic             gen_trig_i,
  input  logic [N_EXT-1:0] ext_src_i,
  output logic             active_o
);
  cfg_t cfg;
  logic rsvd, latched, tq;

  fai_cfg u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_i    (ctrl_i),
    .cfg_o     (cfg),
    .rsvd_o    (rsvd),
    .latched_o (latched)
  );

  fai_qual u_qual (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_i       (cfg),
    .duty_act_i  (duty_act_i),
    .blank_act_i (blank_act_i),
    .gen_trig_i  (gen_trig_i),
    .ext_src_i   (ext_src_i),
    .tq_o        (tq)
  );

  fai_accept u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_i      (cfg),
    .rsvd_i     (rsvd),
    .latched_i  (latched),
    .fault_i    (fault_i),
    .acc_qual_i (acc_qual_i),
    .term_evt_i (term_evt_i),
    .tq_i       (tq),
    .active_o   (active_o)
  );
endmodule

// File: tb/tb_fai_top.sv
`timescale 1ns/1ps
module tb_fai_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ctrl = '0;
  logic        fault = 0, aq = 0, te = 0, duty = 0, blank = 0, trig = 0;
  logic [2:0]  ext = '0;
  logic        active;

  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  string cur_tag = "R1";

  logic [15:0] m_ctrl;
  bit          m_prev, m_lat;

  always #4 clk = ~clk;

  fai_top dut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl), .fault_i(fault),
    .acc_qual_i(aq), .term_evt_i(te), .duty_act_i(duty),
    .blank_act_i(blank), .gen_trig_i(trig), .ext_src_i(ext),
    .active_o(active)
  );

  // behavioural reference
  function automatic void model(output bit e, output bit nl, output bit np);
    int  mode  = int'(m_ctrl[2:0]);
    bit  rdom  = m_ctrl[3];
    int  tsel  = int'(m_ctrl[6:4]);
    bit  tinv  = m_ctrl[7];
    int  route = int'(m_ctrl[9:8]);
    bit  sw    = m_ctrl[10];
    bit  rsv   = (mode > 5) || (route == 3);
    bit  x     = fault | (route == 0 && sw);
    bit  a     = aq    | (route == 1 && sw);
    bit  det, ev, tv, tq, clr;
    case (mode % 3)
      0: det = x;
      1: det = x && !m_prev;
      default: det = x != m_prev;
    endcase
    ev = det && a;
    case (tsel)
      0: tv = 1;
      1: tv = duty;
      2: tv = blank;
      3: tv = trig;
      4: tv = ext[0];
      5: tv = ext[1];
      6: tv = ext[2];
      default: tv = 0;
    endcase
    tq  = (tv ^ tinv) || (route == 2 && sw);
    clr = te && tq;
    if (rsv) e = 0;
    else if (mode >= 3) e = m_lat;
    else e = ev;
    if (rsv || mode < 3) nl = 0;
    else if (ev && clr) nl = !rdom;
    else if (ev) nl = 1;
    else if (clr) nl = 0;
    else nl = m_lat;
    np = x;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= '0; m_prev <= 0; m_lat <= 0;
    end else begin
      bit e, nl, np;
      model(e, nl, np);
      m_ctrl <= ctrl; m_prev <= np; m_lat <= nl;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e, nl, np;
      model(e, nl, np);
      n_chk++;
      if (active !== e) begin
        n_fail++;
        $display("FAIL %s t=%0t ctrl=%h active_o=%b expected=%b", cur_tag, $time, m_ctrl, active, e);
      end
    end
  end

  task automatic step_rand(int n);
    repeat (n) begin
      @(posedge clk); #1;
      fault = 1'($urandom % 2);
      aq    = 1'(($urandom % 4) != 0);
      te    = 1'(($urandom % 3) == 0);
      duty  = 1'($urandom % 2);
      blank = 1'($urandom % 2);
      trig  = 1'($urandom % 2);
      ext   = 3'($urandom % 8);
    end
  endtask

  task automatic set_ctrl(logic [15:0] v);
    @(posedge clk); #1;
    ctrl = v;
  endtask

  // build control word from fields
  function automatic logic [15:0] mk(int mode, bit rdom, int tsel, bit tinv, int route, bit sw);
    return {5'b0, sw, 2'(route), tinv, 3'(tsel), rdom, 3'(mode)};
  endfunction

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired active_o=%b expected=done", active);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    #10;
    n_chk++;
    if (active !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset active_o=%b expected=0", active);
    end
    fault = 1; aq = 1;
    #3 rst_n = 1;
    repeat (4) @(posedge clk);   // R1: zero config gives level acceptance
    cur_tag = "R2";  set_ctrl(mk(0, 0, 0, 0, 3, 0)); set_ctrl(mk(0, 0, 0, 0, 1, 0)); step_rand(300);
    cur_tag = "R3";  set_ctrl(mk(1, 0, 0, 0, 1, 0)); step_rand(300);
    cur_tag = "R4";  set_ctrl(mk(2, 0, 0, 0, 1, 0)); step_rand(300);
    cur_tag = "R5";  set_ctrl(mk(3, 0, 1, 0, 1, 0)); step_rand(300);
    cur_tag = "R6";
    for (int m = 4; m <= 5; m++) begin
      set_ctrl(mk(m, 1, 2, 0, 1, 0)); step_rand(300);
    end
    cur_tag = "R7";
    for (int i = 0; i < 30; i++) begin
      set_ctrl(mk(3 + (i % 3), i[0], 7, 0, 0, 0)); step_rand(10);  // qualifier zero: no clear
      set_ctrl(mk(3 + (i % 3), i[0], 0, 0, 1, 0)); step_rand(10);
    end
    cur_tag = "R8";
    for (int d = 0; d < 2; d++) begin
      set_ctrl(mk(3, d[0], 0, 0, 1, 0));
      for (int k = 0; k < 20; k++) begin
        @(posedge clk); #1;
        fault = 1; aq = 1; te = 1'(k % 2);
      end
      step_rand(100);
    end
    cur_tag = "R9";
    for (int s = 0; s < 8; s++) begin
      set_ctrl(mk(3 + (s % 3), 0, s, 0, 1, 0)); step_rand(120);
    end
    cur_tag = "R10";
    for (int s = 0; s < 8; s++) begin
      set_ctrl(mk(3 + (s % 3), 1, s, 1, 1, 0)); step_rand(80);
    end
    cur_tag = "R11";
    for (int r = 0; r < 3; r++) begin
      for (int m = 0; m < 6; m++) begin
        set_ctrl(mk(m, 0, r == 2 ? 7 : 0, 0, r, 1));
        for (int k = 0; k < 25; k++) begin
          @(posedge clk); #1;
          fault = 1'((r == 0) ? 0 : ($urandom % 2));
          aq    = 1'((r == 1) ? 0 : ($urandom % 2));
          te    = 1'($urandom % 2);
        end
      end
    end
    cur_tag = "R13";
    for (int i = 0; i < 10; i++) begin
      set_ctrl(mk(i % 3, 0, 0, 0, 1, 0)); step_rand(15);
      @(posedge clk); #1; fault = 0; te = 0;
      ctrl = mk(3, 0, 0, 0, 1, 0);
      repeat (4) begin @(posedge clk); #1; fault = 0; end
      step_rand(10);
    end
    cur_tag = "R12";
    for (int i = 0; i < 12; i++) begin
      set_ctrl(mk(6 + (i % 2), 0, 0, 0, 1, 0)); step_rand(20);
      set_ctrl(mk(i % 6, 0, 0, 0, 3, 1)); step_rand(20);
    end
    cur_tag = "R1";
    for (int i = 0; i < 200; i++) begin
      set_ctrl(16'($urandom)); step_rand(3);
    end
    @(posedge clk); #1;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule